// File: doc/BRIEF.md
# Add/Subtract Unit with Skip-on-Carry

This block is the integer add/subtract execution unit of a small RISC core. The core has no carry flag. For each issued operation the unit takes a first operand and a second operand and returns a 32-bit result for the destination register. The second operand comes either from a register or from a sign-extended 16-bit immediate.

Multi-precision arithmetic works through skipping. The skipping variants report a skip length in half-words to the fetch stage. When the low-order step produces no carry, or no borrow for a subtract, the following instruction is skipped. When there is a carry or a borrow, execution falls through, so the next instruction can propagate it into the upper word.

Results appear one clock after issue. Opcodes outside the six defined operations are flagged as invalid. They never write and never skip.

Top module: `asuSkipUnit`

## Requirements
- R1: Opcode encoding (4 bits): 0 = ADD, 1 = ADDS1, 2 = ADDS2, 4 = SUB, 5 = SUBS1, 6 = SUBS2. The add operations return (op2 + op1) mod 2^32.
- R2: The subtract operations return (op2 - op1) mod 2^32.
- R3: When `isImm` is 1, op2 is `imm16` sign-extended to 32 bits and `src2Reg` is ignored. When `isImm` is 0, op2 is `src2Reg` and `imm16` is ignored.
- R4: ADD and SUB always report `skipLen` = 0, even when a carry or borrow occurs.
- R5: ADDS1 and ADDS2 report `skipLen` = 1 and 2 respectively when the unsigned addition produces no carry out of bit 31, and 0 when it does.
- R6: SUBS1 and SUBS2 report `skipLen` = 1 and 2 respectively when there is no borrow (op2 >= op1 unsigned, equality included), and 0 when op2 < op1.
- R7: Any other opcode (3, 7, 8 to 15) gives `invalidOp` = 1, `writeEn` = 0 and `skipLen` = 0.
- R8: Latency is one cycle. `resValid` is high exactly in the cycle after `inValid` was sampled high. Whenever `resValid` is low, `writeEn`, `invalidOp` and `skipLen` are 0.
- R9: While `rstN` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation issued this cycle |
| opcode | input | 4 | Operation select |
| isImm | input | 1 | Selects the immediate as op2 |
| src1 | input | 32 | First operand (op1) |
| src2Reg | input | 32 | Register value for op2 |
| imm16 | input | 16 | Immediate value for op2 |
| resValid | output | 1 | Result cycle |
| result | output | 32 | Value for the destination register |
| writeEn | output | 1 | Destination write request |
| skipLen | output | 2 | Half-words to skip |
| invalidOp | output | 1 | Undefined opcode |

## Verification
The add and subtract paths are each driven with one operand pair that carries or borrows and one that does not. This is repeated for the plain, skip-1 and skip-2 forms, so that the skip length is shown to depend on both the opcode and the carry or borrow. Immediates with the top bit set and with it clear separate true sign extension from zero extension. Register operands are driven with a nonzero immediate alongside, which shows that the unused source is ignored. Equal operands in a subtract and zero plus zero in an add probe the no-borrow and no-carry boundaries. The undefined opcodes in the gaps and at the top of the space confirm that invalid operations produce no write and no skip.

// File: rtl/asuPkg.sv
package asuPkg;
  localparam int OPC_W  = 4;
  localparam int SKIP_W = 2;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD   = 4'h0,
    OP_ADDS1 = 4'h1,
    OP_ADDS2 = 4'h2,
    OP_SUB   = 4'h4,
    OP_SUBS1 = 4'h5,
    OP_SUBS2 = 4'h6
  } asuOpE;

  // strobes from decode to datapath
  typedef struct packed {
    logic              legal;
    logic              doSub;
    logic [SKIP_W-1:0] skipAmt;
  } asuStrobeT;
endpackage

// File: rtl/asuCtrl.sv
module asuCtrl
  import asuPkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output asuStrobeT        strobe
);
  always_comb begin
    strobe = '0;
    case (opcode)
      OP_ADD:   begin strobe.legal = 1'b1; end
      OP_ADDS1: begin strobe.legal = 1'b1; strobe.skipAmt = 2'd1; end
      OP_ADDS2: begin strobe.legal = 1'b1; strobe.skipAmt = 2'd2; end
      OP_SUB:   begin strobe.legal = 1'b1; strobe.doSub = 1'b1; end
      OP_SUBS1: begin strobe.legal = 1'b1; strobe.doSub = 1'b1; strobe.skipAmt = 2'd1; end
      OP_SUBS2: begin strobe.legal = 1'b1; strobe.doSub = 1'b1; strobe.skipAmt = 2'd2; end
      default:  strobe = '0;
    endcase
  end
endmodule

// File: rtl/asuDatapath.sv
module asuDatapath
  import asuPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  asuStrobeT         strobe,
  input  logic              isImm,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2Reg,
  input  logic [IMM_W-1:0]  imm16,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic [SKIP_W-1:0] skipLen,
  output logic              invalidOp
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] op2;
  logic [DATA_W-1:0] addend;
  logic [DATA_W:0]   sumWide;
  logic              carryOut;
  logic              skipTaken;

  assign op2      = isImm ? {{EXT_W{imm16[IMM_W-1]}}, imm16} : src2Reg;
  // subtract as op2 + ~op1 + 1; carry out high means no borrow
  assign addend   = strobe.doSub ? ~src1 : src1;
  assign sumWide  = {1'b0, op2} + {1'b0, addend} + {{DATA_W{1'b0}}, strobe.doSub};
  assign carryOut = sumWide[DATA_W];
  assign skipTaken = strobe.doSub ? carryOut : ~carryOut;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      result    <= '0;
      writeEn   <= 1'b0;
      skipLen   <= '0;
      invalidOp <= 1'b0;
    end else begin
      resValid  <= inValid;
      writeEn   <= inValid & strobe.legal;
      invalidOp <= inValid & ~strobe.legal;
      skipLen   <= (inValid & strobe.legal & skipTaken) ? strobe.skipAmt : '0;
      if (inValid && strobe.legal) result <= sumWide[DATA_W-1:0];
    end
  end
endmodule

// File: rtl/asuSkipUnit.sv
module asuSkipUnit
  import asuPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic              isImm,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2Reg,
  input  logic [IMM_W-1:0]  imm16,
  output logic              resValid,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic [SKIP_W-1:0] skipLen,
  output logic              invalidOp
);
  asuStrobeT strobe;

  asuCtrl u_ctrl (.opcode(opcode), .strobe(strobe));

  asuDatapath #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobe(strobe),
    .isImm(isImm), .src1(src1), .src2Reg(src2Reg), .imm16(imm16),
    .resValid(resValid), .result(result), .writeEn(writeEn),
    .skipLen(skipLen), .invalidOp(invalidOp)
  );
endmodule

// File: rtl/asuSkipUnit_chk.sv
module asuSkipUnit_chk
  import asuPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [OPC_W-1:0]  opcode,
  input logic              isImm,
  input logic [DATA_W-1:0] src1,
  input logic [DATA_W-1:0] src2Reg,
  input logic              resValid,
  input logic [DATA_W-1:0] result,
  input logic              writeEn,
  input logic [SKIP_W-1:0] skipLen,
  input logic              invalidOp
);
  AST_RESET_CLEARS: assert property (@(posedge clk) !rstN |=> (!resValid && !writeEn && skipLen == 0 && !invalidOp)); // R9
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) inValid |=> resValid); // R8
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) !inValid |=> (!resValid && !writeEn && skipLen == 0)); // R8
  AST_INVALID_QUIET: assert property (@(posedge clk) disable iff (!rstN) invalidOp |-> (!writeEn && skipLen == 0 && resValid)); // R7
  AST_BAD_OPCODE: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !(opcode inside {4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'h6})) |=> invalidOp); // R7
  AST_PLAIN_NO_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opcode == 4'h0 || opcode == 4'h4)) |=> skipLen == 0); // R4
  AST_S2_AMOUNT: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opcode == 4'h2 || opcode == 4'h6)) |=> (skipLen == 0 || skipLen == 2)); // R5
  AST_ADD_REG_SUM: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == 4'h0 && !isImm) |=> result == $past(src2Reg + src1)); // R1
  AST_SUB_REG_DIFF: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opcode == 4'h4 && !isImm) |=> result == $past(src2Reg - src1)); // R2
endmodule

bind asuSkipUnit asuSkipUnit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .isImm(isImm),
  .src1(src1), .src2Reg(src2Reg), .resValid(resValid), .result(result),
  .writeEn(writeEn), .skipLen(skipLen), .invalidOp(invalidOp)
);

// File: tb/asuSkipUnit_tb.sv
module asuSkipUnit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  localparam logic [3:0] V_OP [NV] = '{4'h0, 4'h0, 4'h1, 4'h1, 4'h2, 4'h2, 4'h4, 4'h4,
                                       4'h5, 4'h5, 4'h6, 4'h6, 4'h1, 4'h3, 4'h7, 4'hF};
  localparam logic       V_IMM [NV] = '{0,0,0,0,1,1,0,0,0,0,1,0,0,0,0,0};
  localparam logic [31:0] V_A [NV] = '{32'd5, 32'hFFFFFFFF, 32'd1, 32'hFFFFFFFF, 32'd16, 32'd16,
                                       32'd3, 32'd10, 32'd3, 32'd10, 32'd1, 32'd5, 32'd0,
                                       32'd1, 32'd1, 32'd1};
  localparam logic [31:0] V_B [NV] = '{32'd7, 32'd1, 32'd2, 32'd2, 32'h55555555, 32'h55555555,
                                       32'd10, 32'd3, 32'd10, 32'd3, 32'd9, 32'd5, 32'd0,
                                       32'd1, 32'd1, 32'd1};
  localparam logic [15:0] V_I [NV] = '{16'h1234, 16'h1234, 16'h0, 16'h0, 16'hFFFF, 16'h0005,
                                       16'h0, 16'h0, 16'h0, 16'h0, 16'h8000, 16'h0, 16'h0,
                                       16'h0, 16'h0, 16'h0};
  localparam logic [31:0] V_RES [NV] = '{32'd12, 32'd0, 32'd3, 32'd1, 32'h0000000F, 32'h00000015,
                                         32'd7, 32'hFFFFFFF9, 32'd7, 32'hFFFFFFF9, 32'hFFFF7FFF,
                                         32'd0, 32'd0, 32'd0, 32'd0, 32'd0};
  localparam logic       V_WE [NV] = '{1,1,1,1,1,1,1,1,1,1,1,1,1,0,0,0};
  localparam logic [1:0] V_SKIP [NV] = '{2'd0, 2'd0, 2'd1, 2'd0, 2'd0, 2'd2, 2'd0, 2'd0,
                                         2'd1, 2'd0, 2'd2, 2'd2, 2'd1, 2'd0, 2'd0, 2'd0};
  // tags per vector: R1 R4 R5 R5 R3/R5 R3/R5 R2 R4 R6 R6 R3/R6 R6 R5 R7 R7 R7

  logic clk = 0, rstN = 0, inValid = 0, isImm = 0;
  logic [3:0] opcode = 0;
  logic [31:0] src1 = 0, src2Reg = 0;
  logic [15:0] imm16 = 0;
  logic resValid, writeEn, invalidOp;
  logic [31:0] result;
  logic [1:0] skipLen;
  int nRun = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asuSkipUnit u_dut (.clk(clk), .rstN(rstN), .inValid(inValid), .opcode(opcode), .isImm(isImm),
    .src1(src1), .src2Reg(src2Reg), .imm16(imm16), .resValid(resValid), .result(result),
    .writeEn(writeEn), .skipLen(skipLen), .invalidOp(invalidOp));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic im, input logic [31:0] a,
                       input logic [31:0] b, input logic [15:0] i);
    @(negedge clk);
    inValid = 1; opcode = op; isImm = im; src1 = a; src2Reg = b; imm16 = i;
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    // R9 reset state: drive an op during reset
    inValid = 1; opcode = 4'h1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 resValid", {31'b0, resValid}, 0);
    chk("R9 writeEn", {31'b0, writeEn}, 0);
    chk("R9 skipLen", {30'b0, skipLen}, 0);
    chk("R9 invalidOp", {31'b0, invalidOp}, 0);
    @(negedge clk); inValid = 0; rstN = 1;

    for (int k = 0; k < NV; k++) begin
      issue(V_OP[k], V_IMM[k], V_A[k], V_B[k], V_I[k]);
      chk($sformatf("R8 v%0d resValid", k), {31'b0, resValid}, 1);
      chk($sformatf("R1/R2/R3 v%0d writeEn", k), {31'b0, writeEn}, {31'b0, V_WE[k]});
      chk($sformatf("R7 v%0d invalidOp", k), {31'b0, invalidOp}, {31'b0, ~V_WE[k]});
      chk($sformatf("R4/R5/R6 v%0d skipLen", k), {30'b0, skipLen}, {30'b0, V_SKIP[k]});
      if (V_WE[k]) chk($sformatf("R1/R2/R3 v%0d result", k), result, V_RES[k]);
    end

    // R8 idle cycle after back-to-back stream
    @(negedge clk); inValid = 0; opcode = 4'h1; src1 = 0; src2Reg = 0;
    @(posedge clk); #1;
    chk("R8 idle resValid", {31'b0, resValid}, 0);
    chk("R8 idle writeEn", {31'b0, writeEn}, 0);
    chk("R8 idle skipLen", {30'b0, skipLen}, 0);

    // R3 immediate ignored in register form / register ignored in immediate form
    issue(4'h0, 0, 32'd1, 32'd100, 16'h7FFF);
    chk("R3 reg form result", result, 32'd101);
    issue(4'h0, 1, 32'd1, 32'd100, 16'h7FFF);
    chk("R3 imm form result", result, 32'h00008000);
    // R6 largest borrow case, R5 carry at exact wrap
    issue(4'h6, 0, 32'hFFFFFFFF, 32'd0, 16'h0);
    chk("R6 max borrow skip", {30'b0, skipLen}, 0);
    chk("R2 max borrow result", result, 32'd1);
    issue(4'h2, 0, 32'h80000000, 32'h7FFFFFFF, 16'h0);
    chk("R5 no-carry edge skip", {30'b0, skipLen}, 2);

    @(negedge clk); inValid = 0;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule